// File: doc/BRIEF.md
# Backpressured Transaction Queue

This block is a small first-in first-out store for incoming transactions. Its depth is kept small to save area, so it protects itself by raising a stall signal toward the upstream sender. The sender does not stop at once: it may still present valid writes for a fixed number of cycles after the stall appears. The queue therefore raises the stall early enough that every write still in flight finds a free entry.

On the read side, the oldest entry is shown at the head together with a valid flag. It stays there, unchanged, until the consumer pops it, however many cycles that takes. A flush input discards everything in one cycle. The current number of stored entries is always visible. Writes into a full queue and pops from an empty queue are blocked and change nothing.

Top module: `txn_bp_queue`

## Requirements
- R1: After reset, and whenever reset is applied during operation, `occupancy` is 0, `rd_valid` is 0 and `bp_stall` is 0.
- R2: If a write is accepted and no pop is accepted in the same cycle, `occupancy` rises by one at the next clock edge. If a pop is accepted and no write is accepted, `occupancy` falls by one at the next clock edge.
- R3: `occupancy` never exceeds `DEPTH`. A write presented while `occupancy` equals `DEPTH` is dropped, and the stored contents are unchanged.
- R4: A pop presented while `occupancy` is 0 is ignored. `occupancy` stays 0 unless a write is accepted in the same cycle.
- R5: `rd_data` shows the oldest stored entry, and entries leave in the order they were written. While `rd_valid` is 1 and no pop or flush occurs, `rd_data` holds its value across clock edges.
- R6: `bp_stall` is 1 exactly when `occupancy` is at least `DEPTH - BP_LAT`, in the same cycle.
- R7: Suppose the sender keeps writing for `BP_LAT` cycles after it first sees `bp_stall` and then stops, and nothing is popped. Then every write is accepted and `occupancy` settles at `DEPTH`.
- R8: A `flush` makes `occupancy` 0 and `rd_valid` 0 at the next clock edge. It takes priority over a write and a pop in the same cycle, and both are discarded.
- R9: A write and a pop in the same cycle with `0 < occupancy < DEPTH` leave `occupancy` unchanged. The head advances to the next-oldest entry.
- R10: A write and a pop in the same cycle on an empty queue store the written entry, giving `occupancy` 1 with that entry at the head.
- R11: `rd_valid` is 1 exactly when `occupancy` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Sender presents a transaction |
| wr_data | input | DATA_W | Transaction word |
| bp_stall | output | 1 | Stall request toward the sender |
| rd_pop | input | 1 | Consumer removes the head entry |
| rd_valid | output | 1 | Head entry present |
| rd_data | output | DATA_W | Head entry |
| flush | input | 1 | Discard all entries |
| occupancy | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
`occupancy`, `rd_valid` and the head value are registered results, so each one is due at the first clock edge after the stimulus. `bp_stall` follows `occupancy` in the same cycle. The bench drives on the falling edge and checks on the next falling edge, which is after the single register stage. The in-flight-write scenario uses a sender that looks at the stall value seen in the previous cycle. This reproduces the one-cycle reaction delay, and the bench then confirms that the number of words sent equals the number stored and read back.

// File: rtl/txq_pkg.sv
// Shared types and helpers for the backpressured transaction queue.
// Assumes nothing beyond integer parameters passed by the caller.
package txq_pkg;

    // Counter update selected each cycle by the admission logic.
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_UP    = 2'd1,
        CNT_DOWN  = 2'd2,
        CNT_CLEAR = 2'd3
    } cnt_op_e;

    // Occupancy at which the stall is raised: leaves room for lat in-flight writes.
    function automatic int stall_level(input int depth, input int lat);
        if (lat >= depth) return 1;
        return depth - lat;
    endfunction

endpackage

// File: rtl/txq_admit.sv
// Admission logic: decides which requested write and pop are carried out.
// Assumes occ is the registered occupancy; flush wins over both operations.
module txq_admit
    import txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             wr_valid,
    input  logic             rd_pop,
    input  logic             flush,
    input  logic [CNT_W-1:0] occ,
    output logic             wr_en,
    output logic             rd_en,
    output cnt_op_e          cnt_op
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic is_full;
    logic is_empty;

    // Derive full and empty from the stored count.
    always_comb begin
        is_full  = (occ == FULL_CNT);
        is_empty = (occ == '0);
    end

    // Gate requests and choose the counter update.
    always_comb begin
        wr_en = wr_valid && !is_full && !flush;
        rd_en = rd_pop && !is_empty && !flush;
        if (flush)
            cnt_op = CNT_CLEAR;
        else if (wr_en && !rd_en)
            cnt_op = CNT_UP;
        else if (rd_en && !wr_en)
            cnt_op = CNT_DOWN;
        else
            cnt_op = CNT_HOLD;
    end
endmodule

// File: rtl/txq_ptrs.sv
// Pointer and occupancy registers of the queue.
// Assumes wr_en and rd_en were already gated against full, empty and flush.
module txq_ptrs
    import txq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  cnt_op_e          cnt_op,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occ
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    // Advance a pointer with wrap at the last entry (depth need not be a power of two).
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Write pointer: cleared by reset or flush, advanced on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_op == CNT_CLEAR)
            wr_ptr <= '0;
        else if (wr_en)
            wr_ptr <= bump(wr_ptr);
    end

    // Read pointer: cleared by reset or flush, advanced on an accepted pop.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_op == CNT_CLEAR)
            rd_ptr <= '0;
        else if (rd_en)
            rd_ptr <= bump(rd_ptr);
    end

    // Occupancy counter following the admission decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            unique case (cnt_op)
                CNT_UP:    occ <= occ + 1'b1;
                CNT_DOWN:  occ <= occ - 1'b1;
                CNT_CLEAR: occ <= '0;
                default:   occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/txq_store.sv
// Entry storage: one register per entry with its own write strobe, head read by mux.
// Assumes rd_ptr and wr_ptr always stay below DEPTH.
module txq_store #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the incoming word when this slot is the write target.
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(g))
                slot[g] <= wr_data;
        end
    end

    // Present the entry under the read pointer.
    always_comb begin
        rd_data = slot[rd_ptr];
    end
endmodule

// File: rtl/txq_bp_gen.sv
// Stall generator: raises the stall once the free entries equal the sender's reaction delay.
// Assumes the sender stops within BP_LAT cycles after it first sees the stall.
module txq_bp_gen
    import txq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int BP_LAT = 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0] occ,
    output logic             stall
);
    localparam int               LEVEL     = stall_level(DEPTH, BP_LAT);
    localparam logic [CNT_W-1:0] LEVEL_CNT = CNT_W'(LEVEL);

    // Compare the registered occupancy with the stall level.
    always_comb begin
        stall = (occ >= LEVEL_CNT);
    end
endmodule

// File: rtl/txn_bp_queue.sv
// Backpressured transaction queue top: admission, pointers, storage and stall generation.
// Assumes a sender that drops wr_valid within BP_LAT cycles of seeing bp_stall.
module txn_bp_queue
    import txq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int BP_LAT = 1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              bp_stall,
    input  logic              rd_pop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush,
    output logic [CNT_W-1:0]  occupancy
);
    logic             wr_en;
    logic             rd_en;
    cnt_op_e          cnt_op;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] occ;

    txq_admit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_admit (
        .wr_valid (wr_valid),
        .rd_pop   (rd_pop),
        .flush    (flush),
        .occ      (occ),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .cnt_op   (cnt_op)
    );

    txq_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .cnt_op (cnt_op),
        .wr_ptr (wr_ptr),
        .rd_ptr (rd_ptr),
        .occ    (occ)
    );

    txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    txq_bp_gen #(.DEPTH(DEPTH), .BP_LAT(BP_LAT), .CNT_W(CNT_W)) u_bp (
        .occ   (occ),
        .stall (bp_stall)
    );

    // Drive the visible count and the head-present flag.
    always_comb begin
        occupancy = occ;
        rd_valid  = (occ != '0);
    end
endmodule

// File: rtl/txq_checker.sv
// Property checker for the transaction queue, attached to every instance by bind.
// Assumes the same DEPTH and DATA_W as the queue it watches.
module txq_checker #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              rd_pop,
    input logic              flush,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  occupancy
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= FULL_CNT);

    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == FULL_CNT && wr_valid && !rd_pop && !flush) |=> occupancy == FULL_CNT);

    assert_empty_pop_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0 && rd_pop && !wr_valid && !flush) |=> occupancy == '0);

    assert_write_counts_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_pop && !flush && occupancy < FULL_CNT)
            |=> occupancy == $past(occupancy) + 1'b1);

    assert_head_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_pop && !flush) |=> $stable(rd_data));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0 && !rd_valid));

    assert_push_pop_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_pop && !flush && occupancy != '0 && occupancy != FULL_CNT)
            |=> $stable(occupancy));

    assert_valid_tracks_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (occupancy != '0));
endmodule

bind txn_bp_queue txq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_txq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .rd_pop    (rd_pop),
    .flush     (flush),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .occupancy (occupancy)
);

// File: tb/test_txn_bp_queue.sv
`timescale 1ns/100ps
module test_txn_bp_queue;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 8;
    localparam int BP_LAT = 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NVEC   = 15;

    // Vector: flush, wr_valid, rd_pop, wr_data, exp occupancy, exp stall, exp valid, exp head.
    localparam logic [23:0] VECS [NVEC] = '{
        {1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,1'b0,8'h00}, // R4 pop on empty
        {1'b0,1'b1,1'b0,8'h11,3'd1,1'b0,1'b1,8'h11}, // R2 write
        {1'b0,1'b1,1'b0,8'h22,3'd2,1'b0,1'b1,8'h11}, // R2 write
        {1'b0,1'b1,1'b1,8'h33,3'd2,1'b0,1'b1,8'h22}, // R9 write+pop
        {1'b0,1'b0,1'b0,8'h00,3'd2,1'b0,1'b1,8'h22}, // R5 head held
        {1'b0,1'b1,1'b0,8'h44,3'd3,1'b1,1'b1,8'h22}, // R6 stall at level
        {1'b0,1'b1,1'b0,8'h55,3'd4,1'b1,1'b1,8'h22}, // R2 fill to full
        {1'b0,1'b1,1'b0,8'h66,3'd4,1'b1,1'b1,8'h22}, // R3 write when full
        {1'b0,1'b1,1'b1,8'h77,3'd3,1'b1,1'b1,8'h33}, // R3 write blocked, pop taken
        {1'b0,1'b0,1'b1,8'h00,3'd2,1'b0,1'b1,8'h44}, // R5 order, R6 release
        {1'b0,1'b0,1'b1,8'h00,3'd1,1'b0,1'b1,8'h55}, // R5 order
        {1'b0,1'b0,1'b1,8'h00,3'd0,1'b0,1'b0,8'h00}, // R11 empty again
        {1'b0,1'b1,1'b1,8'h88,3'd1,1'b0,1'b1,8'h88}, // R10 write+pop on empty
        {1'b1,1'b1,1'b0,8'h99,3'd0,1'b0,1'b0,8'h00}, // R8 flush beats write
        {1'b0,1'b1,1'b0,8'hAA,3'd1,1'b0,1'b1,8'hAA}  // R8 usable after flush
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_valid;
    logic [DATA_W-1:0] wr_data;
    logic              bp_stall;
    logic              rd_pop;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              flush;
    logic [CNT_W-1:0]  occupancy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    txn_bp_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .BP_LAT(BP_LAT)) i_txn_bp_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .bp_stall  (bp_stall),
        .rd_pop    (rd_pop),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .flush     (flush),
        .occupancy (occupancy)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic step(input logic f, input logic w, input logic p, input logic [DATA_W-1:0] d);
        flush = f; wr_valid = w; rd_pop = p; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0; wr_valid = 1'b0; rd_pop = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; rd_pop = 1'b0; flush = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 occupancy", int'(occupancy), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 bp_stall", int'(bp_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] v;
            v = VECS[i];
            step(v[23], v[22], v[21], v[20:13]);
            check($sformatf("R2/R3/R4/R8/R9/R10 occupancy vec %0d", i), int'(occupancy), int'(v[12:10]));
            check($sformatf("R6 bp_stall vec %0d", i), int'(bp_stall), int'(v[9]));
            check($sformatf("R11 rd_valid vec %0d", i), int'(rd_valid), int'(v[8]));
            if (v[8])
                check($sformatf("R5 head vec %0d", i), int'(rd_data), int'(v[7:0]));
        end

        // R1 reset during operation
        step(1'b0, 1'b1, 1'b0, 8'hBB);
        step(1'b0, 1'b1, 1'b0, 8'hCC);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run occupancy", int'(occupancy), 0);
        check("R1 mid-run rd_valid", int'(rd_valid), 0);
        check("R1 mid-run bp_stall", int'(bp_stall), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 sender that reacts one cycle after seeing the stall
        begin
            logic stall_seen;
            int   sent;
            stall_seen = 1'b0;
            sent = 0;
            for (int c = 0; c < 12; c++) begin
                logic w;
                w = !stall_seen;
                stall_seen = bp_stall;
                if (w) sent++;
                step(1'b0, w, 1'b0, DATA_W'(8'h50 + sent));
            end
            check("R7 words sent", sent, DEPTH);
            check("R7 occupancy full", int'(occupancy), DEPTH);
            check("R3 no overflow", int'(occupancy <= CNT_W'(DEPTH)), 1);
            for (int k = 1; k <= DEPTH; k++) begin
                check($sformatf("R7 drain order %0d", k), int'(rd_data), 8'h50 + k);
                step(1'b0, 1'b0, 1'b1, '0);
            end
            check("R7 drained", int'(occupancy), 0);
        end

        // R4 repeated pops on empty keep queue empty
        step(1'b0, 1'b0, 1'b1, '0);
        step(1'b0, 1'b0, 1'b1, '0);
        check("R4 still empty", int'(occupancy), 0);
        check("R11 valid low", int'(rd_valid), 0);

        // R8 flush while full with a pop
        for (int k = 0; k < DEPTH; k++) step(1'b0, 1'b1, 1'b0, DATA_W'(8'hE0 + k));
        step(1'b1, 1'b0, 1'b1, '0);
        check("R8 flush from full", int'(occupancy), 0);
        check("R8 stall released", int'(bp_stall), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule